// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder

This block turns one Manchester-coded serial line into data bits. A data bit takes two half-bit slots on the line: a 0 is sent low then high, and a 1 is sent high then low. The block runs on a local clock that is a fixed multiple of the half-bit rate, with `OSR` clock cycles in each half-bit slot. Each line transition re-centres a phase counter, so every half-bit is sampled near the middle of its slot. When two half-bits in a row carry the same value, no transition separates them, and the counter then free-runs one slot further.

A plain alternating half-bit stream has no fixed bit boundary: the same waveform reads as all ones or as all zeros. The decoder therefore ignores such a stream until it sees two equal half-bits followed by the opposite value. Low, low, high can only end with a data 0, and high, high, low can only end with a data 1. That event fixes the cell boundary, raises the lock flag and delivers the bit. After that, each pair of half-bits is one cell. A cell whose two halves are equal is a coding error. It raises a one-cycle violation flag and sends the decoder back to searching. A line that stays quiet for more than two bit periods also ends lock and clears the stored half-bit history.

Top module: `manchester_rx`

## Requirements
- R1: A cell of low-then-high (half-bit values 0 then 1) decodes to 0 and high-then-low (1 then 0) decodes to 1. The half-bit stream 01 10 10 10 10 01 01 10, once locked, delivers the bits 0 1 1 1 1 0 0 1 in that order.
- R2: With `OSR` cycles per half-bit (default 8, even, at least 4), every line transition restarts the phase count, and a half-bit is taken `OSR/2` cycles after that restart. Half-bits that run `OSR-1` or `OSR+1` cycles long still decode correctly.
- R3: An alternating half-bit stream with no two equal neighbours never raises `locked` and never pulses `bit_valid`.
- R4: While searching, three half-bits 0,0,1 (oldest first) raise `locked` and deliver a data 0 with `bit_valid` in the same cycle. The next half-bit is taken as the first half of a new cell.
- R5: While searching, three half-bits 1,1,0 (oldest first) raise `locked` and deliver a data 1 in the same way.
- R6: `bit_valid` is high for exactly one cycle. When the second half of a cell starts with a transition, that pulse begins at the `OSR/2+2`-th rising edge after the edge that first samples the new level. `bit_data` holds its value between pulses.
- R7: While locked, a cell whose two halves are equal pulses `violation` for one cycle, drops `locked` in that same cycle and delivers no bit.
- R8: After `4*OSR` cycles with no line transition, `locked` goes low and the stored half-bit history is cleared. Half-bits are not collected again until the next transition, so a following alternating stream does not lock.
- R9: A synchronous active-high `rst` clears the sampler, the phase counter, the history and the lock state. All outputs are 0 in the cycle after `rst` is sampled high.
- R10: After a violation, the search resumes with the history intact, so a violating pair followed by the opposite half-bit locks again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `OSR` cycles per half-bit |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Manchester-coded serial line |
| bit_data | output | 1 | Last recovered data bit |
| bit_valid | output | 1 | One-cycle strobe for a new `bit_data` |
| locked | output | 1 | Cell boundary known |
| violation | output | 1 | One-cycle strobe for an equal-halves cell while locked |

## Verification
A line transition reaches the sampler's half-bit strobe `OSR/2+1` edges after it is first sampled. The decoded bit, the lock change or the violation flag follows one edge later. The timeout fires `4*OSR` edges after the last transition and takes effect on `locked` one edge after that. The bench drives the line on falling edges. A behavioural model updates on every rising edge and is compared with all four outputs at each falling edge, so every result is checked in the exact cycle it is due. The lock-timing case counts falling edges one by one after a transition and expects `bit_valid` only at the `OSR/2+3`-th.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  // Cell tracking states of the aligner
  typedef enum logic [1:0] {
    ST_SEEK   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } cell_state_t;

  // Half-bit histories (oldest in the MSB) that fix a cell boundary
  localparam logic [2:0] PAT_ZERO = 3'b001;
  localparam logic [2:0] PAT_ONE  = 3'b110;
endpackage

// File: rtl/mrx_sampler.sv
module mrx_sampler #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic hb_stb,
  output logic hb_val,
  output logic quiet_tmo
);
  localparam int HALF   = OSR / 2;
  localparam int LIMIT  = 4 * OSR;
  localparam int PH_W   = $clog2(OSR);
  localparam int IDLE_W = $clog2(LIMIT + 1);

  logic              s0, s1;
  logic [PH_W-1:0]   ph;
  logic [IDLE_W-1:0] idle;
  logic              chg;
  logic [PH_W-1:0]   pos;
  logic              quiet;

  assign chg   = s0 ^ s1;
  assign pos   = chg ? '0 : ph;
  assign quiet = (idle == IDLE_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      s0        <= 1'b0;
      s1        <= 1'b0;
      ph        <= '0;
      idle      <= IDLE_W'(LIMIT);
      hb_stb    <= 1'b0;
      hb_val    <= 1'b0;
      quiet_tmo <= 1'b0;
    end else begin
      s0        <= line_in;
      s1        <= s0;
      ph        <= (pos == PH_W'(OSR - 1)) ? '0 : pos + 1'b1;
      idle      <= chg ? '0 : (quiet ? idle : idle + 1'b1);
      hb_stb    <= (pos == PH_W'(HALF)) && !quiet;
      hb_val    <= s0;
      quiet_tmo <= !chg && (idle == IDLE_W'(LIMIT - 1));
    end
  end

  AST_STB_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    hb_stb |=> !hb_stb); // R2
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    quiet_tmo |=> !quiet_tmo); // R8
  AST_NO_STB_AFTER_TMO: assert property (@(posedge clk) disable iff (rst)
    quiet_tmo |=> !hb_stb); // R8
endmodule

// File: rtl/mrx_aligner.sv
module mrx_aligner
  import mrx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hb_stb,
  input  logic hb_val,
  input  logic quiet_tmo,
  output logic bit_data,
  output logic bit_valid,
  output logic locked,
  output logic violation
);
  cell_state_t state;
  logic [2:0]  hist;
  logic [1:0]  fill;
  logic        first_q;
  logic [2:0]  hist_n;
  logic [1:0]  fill_n;

  assign hist_n = {hist[1:0], hb_val};
  assign fill_n = (fill == 2'd3) ? fill : fill + 1'b1;
  assign locked = (state != ST_SEEK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SEEK;
      hist      <= '0;
      fill      <= '0;
      first_q   <= 1'b0;
      bit_data  <= 1'b0;
      bit_valid <= 1'b0;
      violation <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      violation <= 1'b0;
      if (quiet_tmo) begin
        state <= ST_SEEK;
        hist  <= '0;
        fill  <= '0;
      end else if (hb_stb) begin
        hist <= hist_n;
        fill <= fill_n;
        unique case (state)
          ST_SEEK: begin
            if (fill_n == 2'd3 && (hist_n == PAT_ZERO || hist_n == PAT_ONE)) begin
              bit_valid <= 1'b1;
              bit_data  <= hist_n[1];
              state     <= ST_FIRST;
            end
          end
          ST_FIRST: begin
            first_q <= hb_val;
            state   <= ST_SECOND;
          end
          ST_SECOND: begin
            if (hb_val != first_q) begin
              bit_valid <= 1'b1;
              bit_data  <= first_q;
              state     <= ST_FIRST;
            end else begin
              violation <= 1'b1;
              state     <= ST_SEEK;
            end
          end
          default: state <= ST_SEEK;
        endcase
      end
    end
  end

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> locked); // R6
  AST_LOCK_RISE_WITH_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> bit_valid); // R4
  AST_VIOL_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    violation |-> (!locked && !bit_valid)); // R7
  AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    violation |=> !violation); // R7
  AST_TMO_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    quiet_tmo |=> !locked); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid); // R6
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic bit_data,
  output logic bit_valid,
  output logic locked,
  output logic violation
);
  logic hb_stb, hb_val, quiet_tmo;

  mrx_sampler #(.OSR(OSR)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .hb_stb    (hb_stb),
    .hb_val    (hb_val),
    .quiet_tmo (quiet_tmo)
  );

  mrx_aligner u_aligner (
    .clk       (clk),
    .rst       (rst),
    .hb_stb    (hb_stb),
    .hb_val    (hb_val),
    .quiet_tmo (quiet_tmo),
    .bit_data  (bit_data),
    .bit_valid (bit_valid),
    .locked    (locked),
    .violation (violation)
  );
endmodule

// File: tb/test_manchester_rx.sv
module test_manchester_rx;
  localparam int OSR   = 8;
  localparam int HALF  = OSR / 2;
  localparam int LIMIT = 4 * OSR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b0;
  logic bit_data, bit_valid, locked, violation;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  manchester_rx #(.OSR(OSR)) i_manchester_rx (
    .clk(clk), .rst(rst), .line_in(line_in),
    .bit_data(bit_data), .bit_valid(bit_valid),
    .locked(locked), .violation(violation)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: line samples, time since last change, half-bit history
  int m_cur, m_prev, m_run, m_quiet_cnt;
  bit m_take, m_take_val, m_tmo;
  int hq[$];
  bit e_lock, e_valid, e_data, e_viol;
  bit e_second;
  int e_first;

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 0; m_prev = 0; m_run = 0; m_quiet_cnt = LIMIT;
      m_take = 0; m_take_val = 0; m_tmo = 0;
      hq.delete();
      e_lock = 0; e_valid = 0; e_data = 0; e_viol = 0; e_second = 0; e_first = 0;
    end else begin
      bit changed;
      int where;
      e_valid = 0;
      e_viol  = 0;
      if (m_tmo) begin
        e_lock = 0; e_second = 0; hq.delete();
      end else if (m_take) begin
        hq.push_back(int'(m_take_val));
        if (hq.size() > 3) void'(hq.pop_front());
        if (!e_lock) begin
          if (hq.size() == 3 && hq[0] == hq[1] && hq[2] != hq[1]) begin
            e_valid = 1; e_data = hq[1][0]; e_lock = 1; e_second = 0;
          end
        end else if (!e_second) begin
          e_first = int'(m_take_val); e_second = 1;
        end else begin
          e_second = 0;
          if (int'(m_take_val) != e_first) begin
            e_valid = 1; e_data = e_first[0];
          end else begin
            e_viol = 1; e_lock = 0;
          end
        end
      end
      changed = (m_cur != m_prev);
      where   = changed ? 0 : m_run;
      m_take     = (where == HALF) && (m_quiet_cnt < LIMIT);
      m_take_val = m_cur[0];
      m_tmo      = !changed && (m_quiet_cnt == LIMIT - 1);
      m_quiet_cnt = changed ? 0 : ((m_quiet_cnt >= LIMIT) ? LIMIT : m_quiet_cnt + 1);
      m_run  = (where + 1) % OSR;
      m_prev = m_cur;
      m_cur  = int'(line_in);
    end
  end

  // Per-cycle comparison against the reference, and bit collection
  int got[$];
  bit saw_lock, saw_viol;
  always @(negedge clk) begin
    cycles++;
    if (!finished) begin
      chk(bit_valid == e_valid, "R1 bit_valid", bit_valid, e_valid);
      if (e_valid) chk(bit_data == e_data, "R1 bit_data", bit_data, e_data);
      chk(locked == e_lock, "R4 locked", locked, e_lock);
      chk(violation == e_viol, "R7 violation", violation, e_viol);
      if (!rst && bit_valid) got.push_back(int'(bit_data));
      if (locked) saw_lock = 1;
      if (violation) saw_viol = 1;
    end
  end

  task automatic half(input bit v, input int len);
    line_in = v;
    repeat (len) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int l1, input int l2);
    half(b, l1);
    half(!b, l2);
  endtask

  task automatic expect_bits(input string req, input int exp[]);
    #1;
    chk(got.size() == exp.size(), req, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      chk(got[i] == exp[i], req, got[i], exp[i]);
    got.delete();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // r9_ reset state
    chk(!locked && !bit_valid && !violation, "R9 reset outputs", {locked, bit_valid, violation}, 0);
    repeat (6) @(negedge clk);

    // R3: alternating half-bits never lock
    saw_lock = 0;
    for (int i = 0; i < 12; i++) begin
      half(1'b1, OSR);
      half(1'b0, OSR);
    end
    #1;
    chk(saw_lock == 0, "R3 no lock on alternation", saw_lock, 0);
    expect_bits("R3 no bits", '{});

    // R4: 0,0,1 locks with data 0
    half(1'b0, OSR);
    half(1'b1, OSR);
    #1;
    chk(locked == 1, "R4 locked after 001", locked, 1);
    expect_bits("R4 first bit", '{0});

    // R1: known sequence
    begin
      int seq[8] = '{0, 1, 1, 1, 1, 0, 0, 1};
      foreach (seq[i]) send_bit(seq[i][0], OSR, OSR);
      expect_bits("R1 sequence", '{0, 1, 1, 1, 1, 0, 0, 1});
    end

    // R7: equal halves while locked
    saw_viol = 0;
    half(1'b1, OSR);
    half(1'b1, OSR);
    #1;
    chk(saw_viol == 1, "R7 violation seen", saw_viol, 1);
    chk(locked == 0, "R7 lock dropped", locked, 0);
    expect_bits("R7 no bit from bad cell", '{});

    // R10: relock straight from the violating history (1,1,0)
    half(1'b0, OSR);
    #1;
    chk(locked == 1, "R10 relocked", locked, 1);
    send_bit(1'b0, OSR, OSR);
    send_bit(1'b1, OSR, OSR);
    expect_bits("R10 bits after relock", '{1, 0, 1});

    // R2: stretched and shortened half-bits
    begin
      int seq[6] = '{1, 0, 0, 1, 1, 0};
      foreach (seq[i]) send_bit(seq[i][0], (i % 2) ? OSR + 1 : OSR - 1, (i % 2) ? OSR - 1 : OSR + 1);
      expect_bits("R2 jittered bits", '{1, 0, 0, 1, 1, 0});
    end

    // R8: quiet line ends lock and clears history
    half(1'b1, 6 * OSR);
    #1;
    chk(locked == 0, "R8 unlocked after quiet", locked, 0);
    got.delete();
    saw_lock = 0;
    for (int i = 0; i < 6; i++) begin
      half(1'b0, OSR);
      half(1'b1, OSR);
    end
    #1;
    chk(saw_lock == 0, "R8 history cleared, no lock", saw_lock, 0);
    expect_bits("R8 no bits", '{});

    // R6 and R5: 1,1,0 locks with data 1; strobe timing
    half(1'b1, OSR);
    line_in = 1'b0;
    for (int k = 1; k <= HALF + 4; k++) begin
      @(negedge clk);
      #1;
      chk(bit_valid == (k == HALF + 3), "R6 strobe cycle", bit_valid, (k == HALF + 3));
    end
    repeat (OSR - HALF - 4) @(negedge clk);
    chk(locked == 1, "R5 locked after 110", locked, 1);
    expect_bits("R5 data one", '{1});
    send_bit(1'b0, OSR, OSR);
    expect_bits("R5 following bit", '{0});

    // R9: reset while locked
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(!locked && !bit_valid && !violation, "R9 reset while locked",
        {locked, bit_valid, violation}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule